// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This unit turns one decoded memory-operand specifier into either an operand value or a final operand address. A request is a 4-bit addressing-mode code, a 16-bit address field, a 3-bit register index and the current program counter. The unit reads an internal file of eight 16-bit registers directly. When a mode needs a word from memory to locate the operand, it issues reads to a synchronous memory port one at a time. It stops once the final address is known.

Modes without a memory read finish one cycle after the start strobe. Modes that chain through memory finish three cycles after it. Completion is a single-cycle `done` pulse, with the result on a held bus and a flag that tells an operand value from an address. The auto-incrementing indexed mode writes the incremented index register back into the file. The file also has a plain write port used to load it.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done_o`, `mem_rd_o`, `illegal_o` and `is_data_o` are 0 and `result_o` is 0.
- R2: Mode code 0 (immediate) returns the address field as an operand value (`is_data_o`=1), with `done_o` high in the cycle after the start edge and no memory read.
- R3: Mode code 3 (register) returns the contents of the selected register as an operand value (`is_data_o`=1) with no memory read, one cycle after start.
- R4: Mode code 1 (direct) returns the address field, and mode code 4 (register-indirect) returns the selected register, both as addresses (`is_data_o`=0), with no memory read.
- R5: Mode code 5 (displacement) returns field plus register, and mode code 6 (relative) returns field plus `pc_i`, both as addresses modulo 2^16 with no memory read.
- R6: Mode code 7 (indexed) returns field plus the old register value as an address. It also increments that register by 1 modulo 2^16, which is visible to the next request.
- R7: Mode code 2 (indirect) issues exactly one read at the address field and returns the word read as the address.
- R8: Mode code 8 (pre-index) issues exactly one read at field plus register and returns the word read as the address.
- R9: Mode code 9 (post-index) issues exactly one read at the address field and returns the word read plus the register value as the address.
- R10: Mode codes 10 to 15 complete in one cycle with `illegal_o`=1, `result_o`=0 and no memory read. A legal request clears `illegal_o`.
- R11: `done_o` is high for exactly one cycle per accepted request. A start strobe seen while a request is in flight, or in the `done_o` cycle, is ignored.
- R12: `mem_rd_o` is high for one cycle per read. Read data is taken from `mem_rdata_i` in the following cycle, and `done_o` rises two cycles after `mem_rd_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe |
| mode_i | input | 4 | Addressing-mode code |
| afield_i | input | 16 | Address field of the instruction |
| rsel_i | input | 3 | Register index |
| pc_i | input | 16 | Current program counter |
| rf_we_i | input | 1 | Register file load enable |
| rf_waddr_i | input | 3 | Register file load index |
| rf_wdata_i | input | 16 | Register file load data |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 16 | Memory read data, valid one cycle after the request |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Operand value or effective address |
| is_data_o | output | 1 | 1 when `result_o` is an operand value |
| illegal_o | output | 1 | Unsupported mode code on the last request |

## Verification
The assertions assume that memory always answers a read with data in the next cycle. They also assume that a register load aimed at the index an indexed request increments, in the same cycle, is lost to the increment. The bench models a memory whose word is a fixed function of its address with one cycle of latency. It issues loads only while the unit is idle and never in the start cycle of an indexed request. Each request's inputs are held stable until `done_o`, apart from the deliberate overlapping-start scenario.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    AM_IMM  = 4'd0,
    AM_DIR  = 4'd1,
    AM_IND  = 4'd2,
    AM_REG  = 4'd3,
    AM_RIND = 4'd4,
    AM_DISP = 4'd5,
    AM_REL  = 4'd6,
    AM_IDX  = 4'd7,
    AM_PRE  = 4'd8,
    AM_POST = 4'd9
  } am_mode_e;

  typedef struct packed {
    logic legal;     // code is one of the supported modes
    logic needs_rd;  // a memory word is needed to finish
    logic is_data;   // result is an operand value, not an address
    logic wb;        // index register is incremented
    logic post_add;  // register is added after the read
    logic pre_add;   // register is added before the read
  } am_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WT   = 2'd2
  } ea_state_e;

endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [3:0] mode_i,
  output am_ctl_t    ctl_o
);

  always_comb begin
    ctl_o = '0;
    case (mode_i)
      AM_IMM:  begin ctl_o.legal = 1'b1; ctl_o.is_data = 1'b1; end
      AM_DIR:  ctl_o.legal = 1'b1;
      AM_IND:  begin ctl_o.legal = 1'b1; ctl_o.needs_rd = 1'b1; end
      AM_REG:  begin ctl_o.legal = 1'b1; ctl_o.is_data = 1'b1; end
      AM_RIND: ctl_o.legal = 1'b1;
      AM_DISP: ctl_o.legal = 1'b1;
      AM_REL:  ctl_o.legal = 1'b1;
      AM_IDX:  begin ctl_o.legal = 1'b1; ctl_o.wb = 1'b1; end
      AM_PRE:  begin ctl_o.legal = 1'b1; ctl_o.needs_rd = 1'b1; ctl_o.pre_add = 1'b1; end
      AM_POST: begin ctl_o.legal = 1'b1; ctl_o.needs_rd = 1'b1; ctl_o.post_add = 1'b1; end
      default: ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/ea_regfile.sv
module ea_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [RW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic          inc_en_i,
  input  logic [RW-1:0] inc_idx_i,
  input  logic [RW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);

  logic [DW-1:0] regs [NREG];

  // One storage word per register; the increment wins over a load.
  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    wire hit_inc  = inc_en_i && (inc_idx_i == RW'(gi));
    wire hit_load = we_i && (wa_i == RW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        regs[gi] <= '0;
      else if (hit_inc)  regs[gi] <= regs[gi] + DW'(1);
      else if (hit_load) regs[gi] <= wd_i;
    end
  end

  assign rd_o = regs[ra_i];

  // Tracking state for the write-back check.
  logic          inc_seen_q;
  logic [RW-1:0] inc_idx_q;
  logic [DW-1:0] inc_old_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_seen_q <= 1'b0;
      inc_idx_q  <= '0;
      inc_old_q  <= '0;
    end else begin
      inc_seen_q <= inc_en_i;
      inc_idx_q  <= inc_idx_i;
      inc_old_q  <= regs[inc_idx_i];
    end
  end

  AST_INDEX_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    inc_seen_q |-> regs[inc_idx_q] == inc_old_q + DW'(1)); // R6

endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [DW-1:0] afield_i,
  input  logic [RW-1:0] rsel_i,
  input  logic [DW-1:0] pc_i,
  input  logic          rf_we_i,
  input  logic [RW-1:0] rf_waddr_i,
  input  logic [DW-1:0] rf_wdata_i,
  output logic          mem_rd_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic [DW-1:0] result_o,
  output logic          is_data_o,
  output logic          illegal_o
);

  function automatic logic [DW-1:0] wrap_add(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return x + y;
  endfunction

  am_ctl_t       ctl;
  ea_state_e     st_q;
  logic [DW-1:0] rval;
  logic [DW-1:0] quick_val;
  logic [DW-1:0] rd_addr;
  logic [DW-1:0] rlatch_q;
  logic          post_q;
  logic          accept_w;
  logic          inc_en_w;

  ea_decode u_dec (
    .mode_i (mode_i),
    .ctl_o  (ctl)
  );

  ea_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (rf_we_i),
    .wa_i      (rf_waddr_i),
    .wd_i      (rf_wdata_i),
    .inc_en_i  (inc_en_w),
    .inc_idx_i (rsel_i),
    .ra_i      (rsel_i),
    .rd_o      (rval)
  );

  assign accept_w = start_i && (st_q == ST_IDLE) && !done_o;
  assign inc_en_w = accept_w && ctl.wb;

  // Result of the modes that finish without memory.
  always_comb begin
    case (mode_i)
      AM_IMM, AM_DIR:           quick_val = afield_i;
      AM_REG, AM_RIND:          quick_val = rval;
      AM_DISP, AM_IDX:          quick_val = wrap_add(afield_i, rval);
      AM_REL:                   quick_val = wrap_add(afield_i, pc_i);
      default:                  quick_val = '0;
    endcase
  end

  assign rd_addr = ctl.pre_add ? wrap_add(afield_i, rval) : afield_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      done_o     <= 1'b0;
      mem_rd_o   <= 1'b0;
      mem_addr_o <= '0;
      result_o   <= '0;
      is_data_o  <= 1'b0;
      illegal_o  <= 1'b0;
      rlatch_q   <= '0;
      post_q     <= 1'b0;
    end else begin
      done_o   <= 1'b0;
      mem_rd_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept_w) begin
          if (!ctl.legal) begin
            done_o    <= 1'b1;
            illegal_o <= 1'b1;
            result_o  <= '0;
            is_data_o <= 1'b0;
          end else if (ctl.needs_rd) begin
            illegal_o  <= 1'b0;
            mem_rd_o   <= 1'b1;
            mem_addr_o <= rd_addr;
            post_q     <= ctl.post_add;
            rlatch_q   <= rval;
            st_q       <= ST_RD;
          end else begin
            illegal_o <= 1'b0;
            done_o    <= 1'b1;
            result_o  <= quick_val;
            is_data_o <= ctl.is_data;
          end
        end
        ST_RD: st_q <= ST_WT;
        ST_WT: begin
          result_o  <= post_q ? wrap_add(mem_rdata_i, rlatch_q) : mem_rdata_i;
          is_data_o <= 1'b0;
          done_o    <= 1'b1;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o); // R12
  AST_READ_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> ##2 done_o); // R12
  AST_NOREAD_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && !ctl.needs_rd |=> done_o && !mem_rd_o); // R2
  AST_ILLEGAL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && illegal_o |-> result_o == '0 && !is_data_o); // R10

endmodule

// File: tb/ea_unit_test.sv
module ea_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [15:0] afield_i = '0;
  logic [2:0]  rsel_i = '0;
  logic [15:0] pc_i = '0;
  logic        rf_we_i = 1'b0;
  logic [2:0]  rf_waddr_i = '0;
  logic [15:0] rf_wdata_i = '0;
  logic        mem_rd_o;
  logic [15:0] mem_addr_o;
  logic [15:0] mem_rdata_i = '0;
  logic        done_o;
  logic [15:0] result_o;
  logic        is_data_o;
  logic        illegal_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  ea_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .afield_i(afield_i), .rsel_i(rsel_i), .pc_i(pc_i),
    .rf_we_i(rf_we_i), .rf_waddr_i(rf_waddr_i), .rf_wdata_i(rf_wdata_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .result_o(result_o), .is_data_o(is_data_o), .illegal_o(illegal_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'hC3A5;
  endfunction

  always @(posedge clk) if (mem_rd_o) mem_rdata_i <= mem_word(mem_addr_o);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_reg(input logic [2:0] idx, input logic [15:0] val);
    @(negedge clk);
    rf_we_i = 1'b1; rf_waddr_i = idx; rf_wdata_i = val;
    @(negedge clk);
    rf_we_i = 1'b0;
  endtask

  task automatic run(input logic [3:0] m, input logic [15:0] a, input logic [2:0] r,
                     input logic [15:0] pcv, input logic [15:0] exp, input bit exp_data,
                     input int exp_reads, input bit exp_ill, input string req);
    int cyc = 1;
    int reads = 0;
    @(negedge clk);
    mode_i = m; afield_i = a; rsel_i = r; pc_i = pcv; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && cyc < 20) begin
      if (mem_rd_o) reads++;
      @(negedge clk);
      cyc++;
    end
    check(done_o == 1'b1, req, "done seen", 16'(done_o), 16'd1);
    check(result_o == exp, req, "result", result_o, exp);
    check(is_data_o == exp_data, req, "operand flag", 16'(is_data_o), 16'(exp_data));
    check(illegal_o == exp_ill, req, "illegal flag", 16'(illegal_o), 16'(exp_ill));
    check(reads == exp_reads, req, "read count", 16'(reads), 16'(exp_reads));
    check(cyc == (exp_reads != 0 ? 3 : 1), "R12", "done latency", 16'(cyc),
          16'(exp_reads != 0 ? 3 : 1));
    @(negedge clk);
    check(done_o == 1'b0, "R11", "done one cycle", 16'(done_o), 16'd0);
  endtask

  task automatic test_reset();
    check(done_o == 1'b0 && mem_rd_o == 1'b0, "R1", "done/read at reset",
          {14'd0, done_o, mem_rd_o}, 16'd0);
    check(result_o == 16'd0, "R1", "result at reset", result_o, 16'd0);
    check(illegal_o == 1'b0 && is_data_o == 1'b0, "R1", "flags at reset",
          {14'd0, illegal_o, is_data_o}, 16'd0);
  endtask

  task automatic test_busy_ignore();
    int dones = 0;
    @(negedge clk);
    mode_i = 4'd9; afield_i = 16'h0077; rsel_i = 3'd2; start_i = 1'b1;
    @(negedge clk);
    mode_i = 4'd0; afield_i = 16'h5555;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    check(done_o == 1'b1, "R11", "first request done", 16'(done_o), 16'd1);
    check(result_o == mem_word(16'h0077) + 16'h0100, "R11", "first request result",
          result_o, mem_word(16'h0077) + 16'h0100);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (done_o) dones++;
    end
    check(dones == 0, "R11", "overlapping start ignored", 16'(dones), 16'd0);
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected below 100000", cycles);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    load_reg(3'd2, 16'h0100);
    load_reg(3'd3, 16'h0042);
    load_reg(3'd5, 16'hA5A0);
    load_reg(3'd7, 16'hFFFF);

    run(4'd0, 16'h1234, 3'd0, 16'h0, 16'h1234, 1'b1, 0, 1'b0, "R2");
    run(4'd3, 16'h9999, 3'd2, 16'h0, 16'h0100, 1'b1, 0, 1'b0, "R3");
    run(4'd1, 16'hBEEF, 3'd2, 16'h0, 16'hBEEF, 1'b0, 0, 1'b0, "R4");
    run(4'd4, 16'h0000, 3'd5, 16'h0, 16'hA5A0, 1'b0, 0, 1'b0, "R4");
    run(4'd5, 16'h0010, 3'd2, 16'h0, 16'h0110, 1'b0, 0, 1'b0, "R5");
    run(4'd5, 16'h0002, 3'd7, 16'h0, 16'h0001, 1'b0, 0, 1'b0, "R5");
    run(4'd6, 16'hFFF0, 3'd0, 16'h0020, 16'h0010, 1'b0, 0, 1'b0, "R5");
    run(4'd7, 16'h2000, 3'd3, 16'h0, 16'h2042, 1'b0, 0, 1'b0, "R6");
    run(4'd3, 16'h0000, 3'd3, 16'h0, 16'h0043, 1'b1, 0, 1'b0, "R6");
    run(4'd7, 16'h0004, 3'd7, 16'h0, 16'h0003, 1'b0, 0, 1'b0, "R6");
    run(4'd3, 16'h0000, 3'd7, 16'h0, 16'h0000, 1'b1, 0, 1'b0, "R6");
    run(4'd2, 16'h0042, 3'd0, 16'h0, mem_word(16'h0042), 1'b0, 1, 1'b0, "R7");
    run(4'd8, 16'h0040, 3'd2, 16'h0, mem_word(16'h0140), 1'b0, 1, 1'b0, "R8");
    run(4'd9, 16'h0030, 3'd2, 16'h0, mem_word(16'h0030) + 16'h0100, 1'b0, 1, 1'b0, "R9");
    run(4'd10, 16'h1111, 3'd2, 16'h0, 16'h0000, 1'b0, 0, 1'b1, "R10");
    run(4'd15, 16'h2222, 3'd2, 16'h0, 16'h0000, 1'b0, 0, 1'b1, "R10");
    run(4'd1, 16'h0ABC, 3'd0, 16'h0, 16'h0ABC, 1'b0, 0, 1'b0, "R10");
    test_busy_ignore();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule